// File: doc/BRIEF.md
# Quadrature Counter-Timer Channel

This block is one 24-bit counter channel behind a 16-bit word register interface. A host writes a packed mode word that picks the count clock (x4 quadrature decoding of two encoder phases, or the system clock), the counting direction, and how the count is enabled. It fills two 24-bit preload registers with two word writes each, and it issues one-shot commands through a control word. The commands reset the count, load it from the first preload register, or clear a sticky zero-crossing capture flag.

An index input can reload the count from the selected preload register on its rising edge. The count is read as a low word plus a high word that carries the upper byte. A low-word read can freeze the upper byte, so the two halves of a moving count stay coherent. The capture flag is also driven out on a pin, with a polarity set by the mode word.

Top module: `qc_channel`

## Requirements
- R1: After reset the count, both preload registers, the mode word and the capture flag are zero, and every register reads zero.
- R2: Register select 0 reads count bits 15:0, select 1 reads count bits 23:16 in bits 7:0 with bits 15:8 zero, select 2 reads back the mode word, and select 3 reads zero. Read data is registered and valid on the clock after the read strobe.
- R3: A word written to select 0 goes to bits 15:0 of preload 0 when mode bit 14 is 0, and of preload 1 when it is 1. A word written to select 1 puts its bits 7:0 into bits 23:16 of the same preload and discards its upper byte.
- R4: In a write to select 3, bit 15 clears the count, bit 14 loads the count from preload 0, and bit 3 clears the capture flag. Clearing wins over loading, and both win over index reload and counting.
- R5: The count moves only while mode bits 8:7 equal 1 (software enable). Values 0, 2 and 3 hold the count.
- R6: With mode bits 10:9 equal 2, the count steps once per clock. If mode bit 12 is 1, mode bit 11 picks the direction (0 up, 1 down). If mode bit 12 is 0, the count goes up.
- R7: With mode bits 10:9 equal 3, each single-bit change of the synchronized phases {A,B} moves the count by one. The sequence 00,10,11,01 counts up and the reverse counts down. A change of both bits at once is ignored. If mode bit 12 is 1, mode bit 11 overrides the direction.
- R8: The count wraps modulo 2^24 in both directions.
- R9: The capture flag sets when a counting step lands on zero and stays set until a clear command.
- R10: When mode bits 4:2 equal 4, a rising edge of the index input loads the count from the preload register chosen by mode bit 14. Any other value ignores the index input.
- R11: With mode bit 13 at 0, a select-0 read captures the count, and a later select-1 read returns the upper byte of that capture. With bit 13 at 1, select 1 returns the live upper byte.
- R12: The counter output pin equals the capture flag XOR mode bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| enc_a | input | 1 | Encoder phase A (asynchronous) |
| enc_b | input | 1 | Encoder phase B (asynchronous) |
| enc_index | input | 1 | Index pulse (asynchronous) |
| rcap_o | output | 1 | Capture flag |
| ctr_out | output | 1 | Capture flag after polarity selection |

## Verification
Writes to the mode, preload and control registers take effect at the clock edge that samples the strobe. Read data is due one clock after the read strobe. The encoder and index pins pass two synchronizer flops, so they move the count on the third edge after they change. The scoreboard driver queues each expected read word, and the monitor compares the word at the falling edge after the clock that sampled the strobe. Every encoder or index stimulus is held five clocks before the next action, so the count has settled before any read is issued. For internal-clock counting, the number of enabled edges between two mode writes is fixed by the driver's timing, so the exact count is known.

// File: rtl/qc_pkg.sv
package qc_pkg;

  // register selects
  typedef enum logic [1:0] {
    SEL_LO   = 2'd0,
    SEL_HI   = 2'd1,
    SEL_MODE = 2'd2,
    SEL_CTRL = 2'd3
  } regsel_e;

  // packed mode word, bit 15 down to bit 0
  typedef struct packed {
    logic       rsvd;        // 15
    logic       pre_sel;     // 14
    logic       latch_live;  // 13
    logic       dir_sw;      // 12
    logic       dir_down;    // 11
    logic [1:0] clk_src;     // 10:9
    logic [1:0] en_ctl;      // 8:7
    logic [1:0] hw_src;      // 6:5
    logic [2:0] reload_ctl;  // 4:2
    logic       out_pol;     // 1
    logic       out_src;     // 0
  } mode_t;

  localparam logic [1:0] CLK_INTERNAL = 2'd2;
  localparam logic [1:0] CLK_QUAD_X4  = 2'd3;
  localparam logic [1:0] EN_SOFTWARE  = 2'd1;
  localparam logic [2:0] RELOAD_INDEX = 3'd4;

  localparam int CMD_RESET_BIT  = 15;
  localparam int CMD_LOAD_BIT   = 14;
  localparam int CMD_CLRCAP_BIT = 3;

  // {down, up} for a transition of {A,B}; double changes give 00
  function automatic logic [1:0] quad_step(input logic [1:0] prev_ab,
                                           input logic [1:0] cur_ab);
    logic up, dn;
    up = (cur_ab[1] == ~prev_ab[0]) && (cur_ab[0] == prev_ab[1]);
    dn = (cur_ab[1] == prev_ab[0]) && (cur_ab[0] == ~prev_ab[1]);
    return {dn, up};
  endfunction

endpackage

// File: rtl/qc_sync.sv
module qc_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= d_in;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign d_out = stage[STAGES-1];
endmodule

// File: rtl/qc_quad.sv
module qc_quad
  import qc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ab,
  output logic       step_up,
  output logic       step_dn
);
  logic [1:0] prev_ab;
  logic [1:0] step;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_ab <= '0;
    else        prev_ab <= ab;
  end

  assign step    = quad_step(prev_ab, ab);
  assign step_up = step[0];
  assign step_dn = step[1];
endmodule

// File: rtl/qc_counter.sv
module qc_counter
  import qc_pkg::*;
#(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    en_ctl,
  input  logic [1:0]    clk_src,
  input  logic          dir_sw,
  input  logic          dir_down,
  input  logic [2:0]    reload_ctl,
  input  logic [CW-1:0] pr_load,
  input  logic [CW-1:0] pr_index,
  input  logic          cmd_reset,
  input  logic          cmd_load,
  input  logic          cmd_clr_cap,
  input  logic          step_up,
  input  logic          step_dn,
  input  logic          idx_rise,
  output logic [CW-1:0] count,
  output logic          rcap,
  output logic          cnt_inc,
  output logic          cnt_dec,
  output logic          idx_load
);
  function automatic logic [CW-1:0] next_val(input logic [CW-1:0] v,
                                             input logic down);
    return down ? v - CW'(1) : v + CW'(1);
  endfunction

  logic          soft_en, quad_mode, int_mode, tick, going_down, stepping;
  logic [CW-1:0] stepped;

  assign soft_en    = (en_ctl == EN_SOFTWARE);
  assign quad_mode  = (clk_src == CLK_QUAD_X4);
  assign int_mode   = (clk_src == CLK_INTERNAL);
  assign tick       = soft_en && (int_mode || (quad_mode && (step_up || step_dn)));
  assign going_down = dir_sw ? dir_down : (quad_mode && step_dn);
  assign cnt_inc    = tick && !going_down;
  assign cnt_dec    = tick && going_down;
  assign idx_load   = idx_rise && (reload_ctl == RELOAD_INDEX);
  assign stepping   = tick && !cmd_reset && !cmd_load && !idx_load;
  assign stepped    = next_val(count, going_down);

  always_ff @(posedge clk) begin
    if (!rst_n)        count <= '0;
    else if (cmd_reset) count <= '0;
    else if (cmd_load)  count <= pr_load;
    else if (idx_load)  count <= pr_index;
    else if (tick)      count <= stepped;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                         rcap <= 1'b0;
    else if (cmd_clr_cap)               rcap <= 1'b0;
    else if (stepping && stepped == '0) rcap <= 1'b1;
  end
endmodule

// File: rtl/qc_regfile.sv
module qc_regfile
  import qc_pkg::*;
#(
  parameter int CW = 24,
  parameter int BW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          rd,
  input  logic [1:0]    addr,
  input  logic [BW-1:0] wdata,
  input  logic [CW-1:0] count,
  output mode_t         mode,
  output logic [CW-1:0] pr0,
  output logic [CW-1:0] pr1,
  output logic          cmd_reset,
  output logic          cmd_load,
  output logic          cmd_clr_cap,
  output logic [BW-1:0] rdata
);
  localparam int HIW = CW - BW;

  logic [CW-1:0]  pr [2];
  logic [HIW-1:0] hold_hi;
  logic [HIW-1:0] hi_sel;
  logic           wr_lo, wr_hi, wr_mode, wr_ctrl;

  assign wr_lo   = wr && (addr == SEL_LO);
  assign wr_hi   = wr && (addr == SEL_HI);
  assign wr_mode = wr && (addr == SEL_MODE);
  assign wr_ctrl = wr && (addr == SEL_CTRL);

  assign cmd_reset   = wr_ctrl && wdata[CMD_RESET_BIT];
  assign cmd_load    = wr_ctrl && wdata[CMD_LOAD_BIT];
  assign cmd_clr_cap = wr_ctrl && wdata[CMD_CLRCAP_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n)       mode <= '0;
    else if (wr_mode) mode <= mode_t'(wdata);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pr[0] <= '0;
      pr[1] <= '0;
    end else if (wr_lo) begin
      pr[mode.pre_sel][BW-1:0] <= wdata;
    end else if (wr_hi) begin
      pr[mode.pre_sel][CW-1:BW] <= wdata[HIW-1:0];
    end
  end

  assign pr0    = pr[0];
  assign pr1    = pr[1];
  assign hi_sel = mode.latch_live ? count[CW-1:BW] : hold_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata   <= '0;
      hold_hi <= '0;
    end else if (rd) begin
      unique case (addr)
        SEL_LO: begin
          rdata <= count[BW-1:0];
          if (!mode.latch_live) hold_hi <= count[CW-1:BW];
        end
        SEL_HI:   rdata <= {{(BW-HIW){1'b0}}, hi_sel};
        SEL_MODE: rdata <= mode;
        default:  rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/qc_channel.sv
module qc_channel
  import qc_pkg::*;
#(
  parameter int CW          = 24,
  parameter int BW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [BW-1:0] bus_wdata,
  output logic [BW-1:0] bus_rdata,
  input  logic          enc_a,
  input  logic          enc_b,
  input  logic          enc_index,
  output logic          rcap_o,
  output logic          ctr_out
);
  mode_t         mode;
  logic [CW-1:0] pr0, pr1, count, pr_index;
  logic          cmd_reset, cmd_load, cmd_clr_cap;
  logic [2:0]    s_in;
  logic          idx_q, idx_rise;
  logic          step_up, step_dn;
  logic          cnt_inc, cnt_dec, idx_load;
  logic          rcap;

  qc_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_in({enc_index, enc_a, enc_b}), .d_out(s_in)
  );

  qc_quad u_quad (
    .clk(clk), .rst_n(rst_n), .ab(s_in[1:0]),
    .step_up(step_up), .step_dn(step_dn)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) idx_q <= 1'b0;
    else        idx_q <= s_in[2];
  end
  assign idx_rise = s_in[2] && !idx_q;

  qc_regfile #(.CW(CW), .BW(BW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .count(count), .mode(mode), .pr0(pr0), .pr1(pr1),
    .cmd_reset(cmd_reset), .cmd_load(cmd_load), .cmd_clr_cap(cmd_clr_cap),
    .rdata(bus_rdata)
  );

  assign pr_index = mode.pre_sel ? pr1 : pr0;

  qc_counter #(.CW(CW)) u_count (
    .clk(clk), .rst_n(rst_n),
    .en_ctl(mode.en_ctl), .clk_src(mode.clk_src),
    .dir_sw(mode.dir_sw), .dir_down(mode.dir_down),
    .reload_ctl(mode.reload_ctl),
    .pr_load(pr0), .pr_index(pr_index),
    .cmd_reset(cmd_reset), .cmd_load(cmd_load), .cmd_clr_cap(cmd_clr_cap),
    .step_up(step_up), .step_dn(step_dn), .idx_rise(idx_rise),
    .count(count), .rcap(rcap),
    .cnt_inc(cnt_inc), .cnt_dec(cnt_dec), .idx_load(idx_load)
  );

  assign rcap_o  = rcap;
  assign ctr_out = rcap ^ mode.out_pol;
endmodule

// File: rtl/qc_channel_chk.sv
module qc_channel_chk #(
  parameter int CW = 24,
  parameter int BW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] count,
  input logic [CW-1:0] pr0,
  input logic          cnt_inc,
  input logic          cnt_dec,
  input logic          idx_load,
  input logic          cmd_reset,
  input logic          cmd_load,
  input logic          cmd_clr_cap,
  input logic          step_up,
  input logic          step_dn,
  input logic          rcap,
  input logic          bus_rd,
  input logic [1:0]    bus_addr,
  input logic [BW-1:0] bus_rdata
);
  AST_STEP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up && step_dn)); // R7
  AST_CMD_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> (count == '0)); // R4
  AST_CMD_LOADS_PR0: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_load && !cmd_reset) |=> (count == $past(pr0))); // R4
  AST_COUNT_UP_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_inc && !cmd_reset && !cmd_load && !idx_load)
      |=> (count == $past(count) + CW'(1))); // R8
  AST_COUNT_DOWN_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_dec && !cmd_reset && !cmd_load && !idx_load)
      |=> (count == $past(count) - CW'(1))); // R8
  AST_CAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rcap && !cmd_clr_cap) |=> rcap); // R9
  AST_CAP_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clr_cap |=> !rcap); // R4
  AST_HIGH_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd1) |=> (bus_rdata[BW-1:8] == '0)); // R2
endmodule

bind qc_channel qc_channel_chk #(.CW(CW), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .count(count), .pr0(pr0),
  .cnt_inc(cnt_inc), .cnt_dec(cnt_dec), .idx_load(idx_load),
  .cmd_reset(cmd_reset), .cmd_load(cmd_load), .cmd_clr_cap(cmd_clr_cap),
  .step_up(step_up), .step_dn(step_dn), .rcap(rcap),
  .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/test_qc_channel.sv
module test_qc_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        enc_a = 1'b0, enc_b = 1'b0, enc_index = 1'b0;
  logic        rcap_o, ctr_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  // bench model of the counter
  logic [23:0] m_cnt = 24'd0;
  bit          m_quad = 1'b0;
  bit          m_force_dir = 1'b0;
  bit          m_down = 1'b0;
  logic [1:0]  m_ab = 2'b00;

  always #4 clk = ~clk;

  qc_channel i_qc_channel (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .enc_a(enc_a), .enc_b(enc_b), .enc_index(enc_index),
    .rcap_o(rcap_o), .ctr_out(ctr_out)
  );

  // Gray position of {A,B}: 00,10,11,01 ascend
  function automatic int ab_pos(input logic [1:0] ab);
    case (ab)
      2'b00: return 0;
      2'b10: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, input logic [15:0] e, input string tag);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk_count(input logic [23:0] e, input string tag);
    reg_rd(2'd0, e[15:0], tag);
    reg_rd(2'd1, {8'h00, e[23:16]}, tag);
  endtask

  task automatic chk_bit(input logic act, input logic e, input string tag);
    n_tests++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", tag, act, e);
    end
  endtask

  task automatic set_ab(input logic a, input logic b);
    int d;
    @(negedge clk);
    enc_a = a; enc_b = b;
    d = (ab_pos({a, b}) - ab_pos(m_ab) + 4) % 4;
    if (m_quad && (d == 1 || d == 3)) begin
      if (m_force_dir) m_cnt = m_down ? m_cnt - 24'd1 : m_cnt + 24'd1;
      else             m_cnt = (d == 1) ? m_cnt + 24'd1 : m_cnt - 24'd1;
    end
    m_ab = {a, b};
    repeat (5) @(negedge clk);
  endtask

  task automatic pulse_index();
    @(negedge clk);
    enc_index = 1'b1;
    repeat (4) @(negedge clk);
    enc_index = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // monitor: compare registered read data the clock after the strobe
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd) begin
        logic [15:0] e;
        string t;
        @(negedge clk);
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_tests++;
        if (bus_rdata !== e) begin
          n_fail++;
          $display("FAIL %s: read %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_bit(rcap_o, 1'b0, "R1 capture flag");
    reg_rd(2'd2, 16'h0000, "R1 mode");
    chk_count(24'h000000, "R1 count");
    reg_rd(2'd3, 16'h0000, "R2 control reads zero");

    // R3 preload 0 write, R4 load, R2 upper byte zero
    reg_wr(2'd0, 16'h3C68);
    reg_wr(2'd1, 16'hAB12);
    reg_wr(2'd3, 16'h4000);
    chk_count(24'h123C68, "R3 R4 load from preload 0");

    // R4 reset command
    reg_wr(2'd3, 16'h8000);
    chk_count(24'h000000, "R4 reset command");

    // R6 internal clock up: 5 enabled edges
    reg_wr(2'd2, 16'h1480);
    repeat (3) @(negedge clk);
    reg_wr(2'd2, 16'h1400);
    chk_count(24'h000005, "R6 internal up count");

    // R6 down from zero, R8 wrap, R9 no capture on leaving zero
    reg_wr(2'd3, 16'h8000);
    reg_wr(2'd2, 16'h1C80);
    repeat (1) @(negedge clk);
    reg_wr(2'd2, 16'h1400);
    chk_count(24'hFFFFFD, "R8 down wrap");
    chk_bit(rcap_o, 1'b0, "R9 no capture below zero");

    // R8 up wrap to zero sets R9 capture
    reg_wr(2'd2, 16'h1480);
    repeat (1) @(negedge clk);
    reg_wr(2'd2, 16'h1400);
    chk_count(24'h000000, "R8 up wrap");
    chk_bit(rcap_o, 1'b1, "R9 capture on zero");
    repeat (3) @(negedge clk);
    chk_bit(rcap_o, 1'b1, "R9 capture sticky");
    reg_wr(2'd3, 16'h0008);
    chk_bit(rcap_o, 1'b0, "R4 clear capture");

    // R7 quadrature x4
    reg_wr(2'd3, 16'h8000);
    reg_wr(2'd2, 16'h0680);
    m_cnt = 24'd0; m_quad = 1'b1; m_force_dir = 1'b0;
    set_ab(1, 0); set_ab(1, 1); set_ab(0, 1); set_ab(0, 0);
    chk_count(m_cnt, "R7 quad forward");
    set_ab(0, 1); set_ab(1, 1);
    chk_count(m_cnt, "R7 quad reverse");
    m_quad = 1'b0;
    set_ab(0, 0);
    chk_count(m_cnt, "R7 double change ignored");

    // R7 forced direction in quadrature mode
    reg_wr(2'd2, 16'h1E80);
    m_quad = 1'b1; m_force_dir = 1'b1; m_down = 1'b1;
    set_ab(1, 0);
    chk_count(m_cnt, "R7 forced down");

    // R5 enable control other than software holds count
    m_quad = 1'b0;
    reg_wr(2'd2, 16'h0600);
    set_ab(1, 1); set_ab(0, 1);
    chk_count(m_cnt, "R5 enable 0 holds");
    reg_wr(2'd2, 16'h0700);
    set_ab(0, 0);
    chk_count(m_cnt, "R5 enable 2 holds");

    // R3 preload 1 write (upper byte discarded), R10 index reload
    reg_wr(2'd2, 16'h4000);
    reg_wr(2'd0, 16'h1111);
    reg_wr(2'd1, 16'hFF22);
    pulse_index();
    chk_count(m_cnt, "R10 index ignored without reload mode");
    reg_wr(2'd2, 16'h4010);
    pulse_index();
    chk_count(24'h221111, "R10 R3 index reload from preload 1");

    // R11 latched upper byte
    reg_wr(2'd2, 16'h0000);
    reg_rd(2'd0, 16'h1111, "R11 low read captures");
    reg_wr(2'd3, 16'h4000);
    reg_rd(2'd1, 16'h0022, "R11 high from capture");
    reg_wr(2'd2, 16'h2000);
    reg_rd(2'd1, 16'h0012, "R11 live high");
    reg_rd(2'd2, 16'h2000, "R2 mode readback");

    // R4 reset wins over load
    reg_wr(2'd3, 16'hC000);
    chk_count(24'h000000, "R4 reset over load");

    // R12 output polarity
    reg_wr(2'd2, 16'h0002);
    chk_bit(ctr_out, 1'b1, "R12 inverted output");
    chk_bit(rcap_o, 1'b0, "R12 flag unchanged");
    reg_wr(2'd2, 16'h0000);
    chk_bit(ctr_out, 1'b0, "R12 direct output");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule